// File: doc/BRIEF.md
# Reset Source and Sleep-Wake Controller

This block merges the chip's reset causes (power-on, low-voltage detection, an external active-low reset pin and a watchdog overflow) into one stretched, active-low system reset. It also keeps two status bits, a timeout flag (TO) and a power-down flag (PD), that firmware reads after a restart to find out why the core restarted and whether it was asleep at the time.

The same state machine handles sleep. A sleep strobe from the core takes a snapshot of the 8-bit port B and parks the core. The core wakes without a reset when an enabled input pin differs from that snapshot. In internal-watchdog-wake mode, a watchdog overflow during sleep also wakes the core. That path first waits a clock-settle delay, whose length is picked by a select bit. In this mode the top port-B wake bit is forced off.

The four states are `ST_RESET` (reset held and stretched), `ST_RUN` (core executing), `ST_SLEEP` (core parked, waiting for a wake event) and `ST_SETTLE` (waiting for the clock to settle after a watchdog wake).

The transitions are:
- `ST_RESET` goes to `ST_RUN` once the stretch count of slow ticks has elapsed with no reset source active.
- `ST_RUN` goes to `ST_SLEEP` on the sleep strobe.
- `ST_RUN` goes to `ST_RESET` on a watchdog overflow.
- `ST_SLEEP` goes to `ST_RUN` on a pin change.
- `ST_SLEEP` goes to `ST_SETTLE` on a watchdog overflow in internal-wake mode.
- `ST_SLEEP` goes to `ST_RESET` on a watchdog overflow in any other mode.
- `ST_SETTLE` goes to `ST_RUN` once the settle count has elapsed.
- Any state goes to `ST_RESET` on a low-voltage event or on an enabled pin reset.

Top module: `rstw_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst_n`=0, TO=1 and PD=1. After `por_n` rises, `sys_rst_n` stays low for RST_TICKS `slow_tick` pulses (default 4) and then goes high.
- R2: A low on `lvd_n` forces the reset and sets TO=1 and PD=1. The reset is stretched again from the release of `lvd_n`. A low-voltage event takes priority over every other source.
- R3: `pin_rst_n` low resets the block only when `pin_rst_en`=1. A pin reset in `ST_RUN` leaves TO and PD unchanged. A pin reset while asleep gives TO=1 and PD=0. With `pin_rst_en`=0 the pin has no effect.
- R4: `wdt_ovf` in `ST_RUN` resets the block and gives TO=0, PD=1.
- R5: `wdt_ovf` in `ST_SLEEP` with `iwake_mode`=0 resets the block and gives TO=0, PD=0.
- R6: `sleep_stb` in `ST_RUN` sets `asleep`=1, TO=1 and PD=0, and captures `pb_in` as the wake snapshot.
- R7: `clrwdt_stb` in `ST_RUN` sets TO=1 and PD=1.
- R8: In `ST_SLEEP`, a port-B bit wakes the core when three conditions hold: its `wake_en` bit is 1, its `pb_is_input` bit is 1 (1 means input), and its value differs from the snapshot. A wake pulses `wake` for one cycle, clears `asleep`, gives TO=1 and PD=0, and causes no reset. Disabled bits and output bits are ignored.
- R9: With `iwake_mode`=1, wake-enable bit 7 is ignored. A `wdt_ovf` during sleep then wakes the core without a reset and gives TO=0, PD=0. The wake waits STAB_LONG ticks (default 8) when `stab_sel`=0, or STAB_SHORT ticks (default 4) when `stab_sel`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| lvd_n | input | 1 | Low-voltage detector output, active low |
| pin_rst_n | input | 1 | External reset pin, active low |
| pin_rst_en | input | 1 | Configuration bit: 1 makes the pin act as a reset |
| slow_tick | input | 1 | One-cycle strobe from the slow clock domain |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| sleep_stb | input | 1 | Sleep instruction strobe |
| clrwdt_stb | input | 1 | Clear-watchdog instruction strobe |
| pb_in | input | 8 | Port B pin levels |
| pb_is_input | input | 8 | Port B direction, 1 = input |
| wake_en | input | 8 | Per-pin wake enable |
| iwake_mode | input | 1 | Internal-watchdog-wake mode |
| stab_sel | input | 1 | Settle select: 0 long, 1 short |
| sys_rst_n | output | 1 | Stretched system reset, active low |
| asleep | output | 1 | Core is parked (sleep or settle) |
| wake | output | 1 | One-cycle wake pulse |
| to_flag | output | 1 | Timeout status bit |
| pd_flag | output | 1 | Power-down status bit |

## Verification
A wrong state shows first on `sys_rst_n` and `asleep`. A missed transition leaves either output at the wrong level within a few clocks of the strobe, or within the synchronizer delay for the pin and voltage inputs. A wrong flag update appears on `to_flag`/`pd_flag` one cycle after the event and persists until the next event, so the bench reads the flags after each cause. Stretch and settle counts are checked by sampling before and after their nominal windows, which exposes an off-by-a-tick error as early or late release.

// File: rtl/rstw_pkg.sv
package rstw_pkg;
    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_RUN    = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_SETTLE = 2'd3
    } rstw_state_e;
endpackage

// File: rtl/rstw_sync.sv
module rstw_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/rstw_wake_detect.sv
module rstw_wake_detect #(
    parameter int PB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PB_W-1:0] pb_in,
    input  logic [PB_W-1:0] pb_is_input,
    input  logic [PB_W-1:0] wake_en,
    input  logic            iwake_mode,
    output logic            hit
);
    logic [PB_W-1:0] snap;
    logic [PB_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    snap <= '0;
        else if (load) snap <= pb_in;
    end

    for (genvar i = 0; i < PB_W; i++) begin : g_mask
        if (i == PB_W - 1) begin : g_top
            assign mask[i] = wake_en[i] & pb_is_input[i] & ~iwake_mode;
        end else begin : g_low
            assign mask[i] = wake_en[i] & pb_is_input[i];
        end
    end

    assign hit = |((pb_in ^ snap) & mask);

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(snap)); // R8
endmodule

// File: rtl/rstw_ctrl.sv
module rstw_ctrl
    import rstw_pkg::*;
#(
    parameter int PB_W       = 8,
    parameter int RST_TICKS  = 4,
    parameter int STAB_LONG  = 8,
    parameter int STAB_SHORT = 4
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            lvd_n,
    input  logic            pin_rst_n,
    input  logic            pin_rst_en,
    input  logic            slow_tick,
    input  logic            wdt_ovf,
    input  logic            sleep_stb,
    input  logic            clrwdt_stb,
    input  logic [PB_W-1:0] pb_in,
    input  logic [PB_W-1:0] pb_is_input,
    input  logic [PB_W-1:0] wake_en,
    input  logic            iwake_mode,
    input  logic            stab_sel,
    output logic            sys_rst_n,
    output logic            asleep,
    output logic            wake,
    output logic            to_flag,
    output logic            pd_flag
);
    localparam int MAXC = (RST_TICKS > STAB_LONG) ? RST_TICKS : STAB_LONG;
    localparam int CW   = $clog2(MAXC + 1);

    rstw_state_e     state, nxt;
    logic            to_q, pd_q, to_d, pd_d, wake_q, wake_d;
    logic [CW-1:0]   cnt, cnt_d, settle_last;
    logic            lvd_s, pin_s, pin_act, snap_ld, pin_hit;
    logic [1:0]      sync_q;

    rstw_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     ({lvd_n, pin_rst_n}),
        .q     (sync_q)
    );
    assign lvd_s   = sync_q[1];
    assign pin_s   = sync_q[0];
    assign pin_act = pin_rst_en & ~pin_s;

    rstw_wake_detect #(.PB_W(PB_W)) u_wake (
        .clk         (clk),
        .rst_n       (por_n),
        .load        (snap_ld),
        .pb_in       (pb_in),
        .pb_is_input (pb_is_input),
        .wake_en     (wake_en),
        .iwake_mode  (iwake_mode),
        .hit         (pin_hit)
    );

    assign settle_last = stab_sel ? CW'(STAB_SHORT - 1) : CW'(STAB_LONG - 1);

    // next state and flag updates
    always_comb begin
        nxt     = state;
        to_d    = to_q;
        pd_d    = pd_q;
        cnt_d   = cnt;
        wake_d  = 1'b0;
        snap_ld = 1'b0;
        if (!lvd_s) begin
            nxt = ST_RESET; to_d = 1'b1; pd_d = 1'b1; cnt_d = '0;
        end else if (pin_act) begin
            nxt = ST_RESET; cnt_d = '0;
            if (state == ST_SLEEP || state == ST_SETTLE) begin
                to_d = 1'b1; pd_d = 1'b0;
            end
        end else begin
            unique case (state)
                ST_RESET: begin
                    if (slow_tick) begin
                        if (cnt == CW'(RST_TICKS - 1)) begin
                            nxt = ST_RUN; cnt_d = '0;
                        end else begin
                            cnt_d = cnt + 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (wdt_ovf) begin
                        nxt = ST_RESET; to_d = 1'b0; pd_d = 1'b1; cnt_d = '0;
                    end else if (sleep_stb) begin
                        nxt = ST_SLEEP; to_d = 1'b1; pd_d = 1'b0; snap_ld = 1'b1;
                    end else if (clrwdt_stb) begin
                        to_d = 1'b1; pd_d = 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (wdt_ovf) begin
                        to_d = 1'b0; pd_d = 1'b0; cnt_d = '0;
                        nxt  = iwake_mode ? ST_SETTLE : ST_RESET;
                    end else if (pin_hit) begin
                        nxt = ST_RUN; to_d = 1'b1; pd_d = 1'b0; wake_d = 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (slow_tick) begin
                        if (cnt == settle_last) begin
                            nxt = ST_RUN; cnt_d = '0; wake_d = 1'b1;
                        end else begin
                            cnt_d = cnt + 1'b1;
                        end
                    end
                end
                default: nxt = ST_RESET;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state  <= ST_RESET;
            to_q   <= 1'b1;
            pd_q   <= 1'b1;
            cnt    <= '0;
            wake_q <= 1'b0;
        end else begin
            state  <= nxt;
            to_q   <= to_d;
            pd_q   <= pd_d;
            cnt    <= cnt_d;
            wake_q <= wake_d;
        end
    end

    // outputs
    always_comb begin
        sys_rst_n = (state != ST_RESET);
        asleep    = (state == ST_SLEEP) || (state == ST_SETTLE);
        wake      = wake_q;
        to_flag   = to_q;
        pd_flag   = pd_q;
    end

    AST_LVD_RESETS: assert property (@(posedge clk) disable iff (!por_n)
        !lvd_s |=> (!sys_rst_n && to_flag && pd_flag)); // R2
    AST_WDT_RUN_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && wdt_ovf && lvd_s && !pin_act) |=> (!sys_rst_n && !to_flag && pd_flag)); // R4
    AST_SLEEP_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && sleep_stb && !wdt_ovf && lvd_s && !pin_act) |=> (asleep && to_flag && !pd_flag)); // R6
    AST_CLRWDT_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && clrwdt_stb && !sleep_stb && !wdt_ovf && lvd_s && !pin_act) |=> (to_flag && pd_flag)); // R7
    AST_IWAKE_NO_RESET: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_SLEEP && wdt_ovf && iwake_mode && lvd_s && !pin_act) |=> (sys_rst_n && asleep)); // R9
    AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wake) |-> ($past(state) == ST_SLEEP || $past(state) == ST_SETTLE)); // R8
endmodule

// File: tb/rstw_ctrl_tb.sv
module rstw_ctrl_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, lvd_n = 1'b1, pin_rst_n = 1'b1, pin_rst_en = 1'b0;
    logic       slow_tick = 1'b0, wdt_ovf = 1'b0, sleep_stb = 1'b0, clrwdt_stb = 1'b0;
    logic [7:0] pb_in = 8'h00, pb_is_input = 8'hFF, wake_en = 8'h00;
    logic       iwake_mode = 1'b0, stab_sel = 1'b0;
    logic       sys_rst_n, asleep, wake, to_flag, pd_flag;
    int         n_chk = 0, n_fail = 0;
    logic [1:0] div = '0;
    logic       seen_wake = 1'b0, clr_seen = 1'b0, done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        div       <= div + 2'd1;
        slow_tick <= (div == 2'd3);
        seen_wake <= clr_seen ? 1'b0 : (seen_wake | wake);
    end

    rstw_ctrl u_dut (
        .clk(clk), .por_n(por_n), .lvd_n(lvd_n), .pin_rst_n(pin_rst_n),
        .pin_rst_en(pin_rst_en), .slow_tick(slow_tick), .wdt_ovf(wdt_ovf),
        .sleep_stb(sleep_stb), .clrwdt_stb(clrwdt_stb), .pb_in(pb_in),
        .pb_is_input(pb_is_input), .wake_en(wake_en), .iwake_mode(iwake_mode),
        .stab_sel(stab_sel), .sys_rst_n(sys_rst_n), .asleep(asleep), .wake(wake),
        .to_flag(to_flag), .pd_flag(pd_flag)
    );

    // {dir, en, iwake, toggle, expect_wake}
    localparam logic [25:0] VEC [6] = '{
        {8'hFF, 8'h01, 1'b0, 8'h01, 1'b1},
        {8'hFF, 8'h01, 1'b0, 8'h02, 1'b0},
        {8'hFE, 8'h01, 1'b0, 8'h01, 1'b0},
        {8'hFF, 8'h80, 1'b0, 8'h80, 1'b1},
        {8'hFF, 8'h80, 1'b1, 8'h80, 1'b0},
        {8'hFF, 8'h3C, 1'b1, 8'h24, 1'b1}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_sleep();
        sleep_stb = 1'b1; cyc(1); sleep_stb = 1'b0; cyc(1);
    endtask
    task automatic pulse_wdt();
        wdt_ovf = 1'b1; cyc(1); wdt_ovf = 1'b0; cyc(1);
    endtask
    task automatic pulse_clr();
        clrwdt_stb = 1'b1; cyc(1); clrwdt_stb = 1'b0; cyc(1);
    endtask

    // {sys_rst_n, asleep, to, pd}
    function automatic logic [7:0] st();
        return {4'h0, sys_rst_n, asleep, to_flag, pd_flag};
    endfunction

    initial begin
        cyc(3);
        check("R1 reset held, TO=1 PD=1", st(), 8'h03);
        por_n = 1'b1;
        cyc(8);
        check("R1 stretch still low", {7'h0, sys_rst_n}, 8'h00);
        cyc(30);
        check("R1 released", st(), 8'h0B);

        // R6 sleep entry
        pb_in = 8'h00; wake_en = 8'h01;
        pulse_sleep();
        check("R6 sleep TO=1 PD=0", st(), 8'h0E);
        wake_en = 8'hFF; pb_in = 8'h01; cyc(4); pb_in = 8'h00; cyc(2);

        // R8/R9 pin-change table
        foreach (VEC[k]) begin
            pb_is_input = VEC[k][25:18];
            wake_en     = VEC[k][17:10];
            iwake_mode  = VEC[k][9];
            pb_in       = 8'h00;
            cyc(2);
            pulse_sleep();
            clr_seen = 1'b1; cyc(1); clr_seen = 1'b0;
            pb_in = VEC[k][8:1];
            cyc(6);
            if (VEC[k][0])
                check($sformatf("R8 vec%0d wake", k), {6'h0, seen_wake, asleep}, 8'h02);
            else
                check($sformatf("R8 R9 vec%0d ignored", k), {6'h0, seen_wake, asleep}, 8'h01);
            check($sformatf("R8 vec%0d no reset PD=0", k), {6'h0, sys_rst_n, pd_flag}, 8'h02);
            iwake_mode = 1'b0; pb_is_input = 8'hFF; wake_en = 8'hFF;
            cyc(4);
            pb_in = 8'h00; cyc(2);
        end

        // R7 clear watchdog
        pulse_clr();
        check("R7 clrwdt TO=1 PD=1", st(), 8'h0B);

        // R4 watchdog in run
        pulse_wdt();
        check("R4 wdt run reset TO=0 PD=1", st(), 8'h01);
        cyc(40);
        check("R4 back to run", st(), 8'h09);

        // R3 pin disabled, then enabled in run
        pin_rst_en = 1'b0; pin_rst_n = 1'b0; cyc(10);
        check("R3 pin ignored when disabled", st(), 8'h09);
        pin_rst_en = 1'b1; cyc(6);
        check("R3 pin reset run flags unchanged", st(), 8'h01);
        pin_rst_n = 1'b1; cyc(40);
        check("R3 released", {7'h0, sys_rst_n}, 8'h01);

        // R3 pin reset while asleep
        wake_en = 8'h00; pulse_sleep();
        pin_rst_n = 1'b0; cyc(6);
        check("R3 pin reset in sleep TO=1 PD=0", st(), 8'h02);
        pin_rst_n = 1'b1; pin_rst_en = 1'b0; cyc(40);

        // R5 watchdog in sleep without internal wake
        pulse_sleep(); cyc(2);
        pulse_wdt();
        check("R5 wdt sleep reset TO=0 PD=0", st(), 8'h00);
        cyc(40);

        // R9 internal wake, long settle
        iwake_mode = 1'b1; stab_sel = 1'b0;
        pulse_sleep(); cyc(2);
        clr_seen = 1'b1; cyc(1); clr_seen = 1'b0;
        pulse_wdt(); cyc(22);
        check("R9 long settle still asleep, no reset", st(), 8'h0C);
        cyc(30);
        check("R9 long settle woke TO=0 PD=0", {3'h0, seen_wake, sys_rst_n, asleep, to_flag, pd_flag}, 8'h18);

        // R9 short settle
        stab_sel = 1'b1;
        pulse_sleep(); cyc(2);
        pulse_wdt(); cyc(22);
        check("R9 short settle woke", st(), 8'h08);
        iwake_mode = 1'b0;

        // R2 low-voltage
        lvd_n = 1'b0; cyc(6);
        check("R2 lvd reset TO=1 PD=1", st(), 8'h03);
        lvd_n = 1'b1; cyc(8);
        check("R2 stretch after release", {7'h0, sys_rst_n}, 8'h00);
        cyc(32);
        check("R2 released", st(), 8'h0B);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule